// File: doc/BRIEF.md
# DRAM refresh interval timer

This block paces DRAM refresh. An 8-bit interval counter advances once per tick of a prescaled enable, picked from a set of tick inputs by a 3-bit select. When the counter equals a programmable constant on a tick, the block does four things. It clears the counter to zero, sets a compare-match flag, and pulses a refresh request for one clock. The same event also adds one to a refresh tally.

A refresh request can arrive while the tally already stands at the chosen limit (1024 or 512). In that case the tally restarts at zero and an overflow flag is set. The overflow flag drives a level interrupt when its enable bit is set. Both flags are status bits that software clears by writing 0; a write of 1 leaves them as they are.

There are two reset inputs. Power-on reset clears everything. Manual reset clears the control and status bits, the tally and the request output, but leaves the interval counter and the constant alone, so the counter keeps counting. In standby the counter holds its value.

Each flag is a two-state machine. FLAG_LOW moves to FLAG_HIGH on its hardware set event (transition SET). FLAG_HIGH moves back to FLAG_LOW on a software write of 0 when no set event happens in the same cycle (transition CLEAR), or on manual reset (transition MRESET). Power-on reset forces FLAG_LOW.

Top module: `refresh_interval_timer`

## Requirements
- R1: The interval counter advances only in a cycle where `tick_sel` is nonzero, bit `tick_sel-1` of `tick_vec` is 1 and `standby` is 0. A select of 0 stops it, and a tick on any other bit of `tick_vec` has no effect.
- R2: A tick while the counter equals the constant clears the counter and sets the compare-match flag. It also drives `refresh_req` high for exactly the next cycle. Any other tick adds one to the counter. Starting from 0 with constant C, K ticks therefore give floor(K/(C+1)) requests and leave the counter at K mod (C+1).
- R3: Each refresh request adds one to the refresh tally at address 3.
- R4: The limit select is CSR bit 0: 0 selects a limit of 1024 and 1 selects 512. A request that arrives while the tally equals the limit sets the overflow flag (CSR bit 2) and returns the tally to 0.
- R5: Writing 0 to the overflow flag (bit 2) or the compare-match flag (bit 3) clears it. Writing 1 to either leaves it unchanged.
- R6: When a hardware set event and a software write of 0 reach a flag in the same cycle, the flag is set.
- R7: `irq` is 1 exactly while the overflow flag and the interrupt enable (CSR bit 1) are both 1, and it stays high until the flag is cleared.
- R8: Power-on reset clears all registers and outputs. Manual reset clears the CSR, the tally and `refresh_req`, but keeps the counter and the constant, and the counter goes on advancing during manual reset.
- R9: The register map is: address 0 CSR, 1 counter, 2 constant, 3 tally. All four are readable on `reg_rdata` in the same cycle and writable with `reg_we`. A write to the counter takes precedence over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, synchronous, active high |
| standby | input | 1 | Freezes the interval counter |
| tick_sel | input | 3 | Tick source select, 0 = stopped |
| tick_vec | input | 7 | Prescaled tick enables |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 11 | Register read data |
| refresh_req | output | 1 | One-cycle refresh request |
| irq | output | 1 | Overflow interrupt level |

## Verification
The flag machines can see a hardware set and a software clear in the same cycle. The bench sets this up with the timer stopped, the constant at 0 and the tally preloaded at the limit. It then opens a single tick cycle and, in that same cycle, writes 0 to both flag bits of the CSR. Both flags must read 1 afterwards and `irq` must be high. A following plain write of 0 must then clear both flags.

// File: rtl/rit_pkg.sv
package rit_pkg;
    typedef enum logic [1:0] {
        RA_CSR = 2'd0,
        RA_CNT = 2'd1,
        RA_CMP = 2'd2,
        RA_RC  = 2'd3
    } reg_addr_t;

    localparam int CSR_LMTS = 0;
    localparam int CSR_OVIE = 1;
    localparam int CSR_OVF  = 2;
    localparam int CSR_CMF  = 3;

    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_t;
endpackage

// File: rtl/rit_tick_sel.sv
module rit_tick_sel #(
    parameter int SEL_W = 3,
    localparam int NTICK = (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0] tick_sel,
    input  logic [NTICK-1:0] tick_vec,
    input  logic             standby,
    output logic             tick
);
    logic tick_raw;

    always_comb begin
        tick_raw = 1'b0;
        for (int k = 1; k <= NTICK; k++) begin
            if (tick_sel == SEL_W'(k)) tick_raw = tick_vec[k-1];
        end
    end

    assign tick = tick_raw && !standby;
endmodule

// File: rtl/rit_interval.sv
module rit_interval #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_cmp,
    input  logic [TMR_W-1:0] wdata,
    output logic [TMR_W-1:0] cnt_q,
    output logic [TMR_W-1:0] cmp_q,
    output logic             match,
    output logic             req_q
);
    assign match = tick && !wr_cnt && (cnt_q == cmp_q);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wdata;
        else if (match)  cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= wdata;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)    req_q <= 1'b0;
        else if (mrst) req_q <= 1'b0;
        else           req_q <= match;
    end
endmodule

// File: rtl/rit_tally.sv
module rit_tally #(
    parameter int LIMIT_LO = 512,
    parameter int LIMIT_HI = 1024,
    localparam int RC_W = $clog2(LIMIT_HI + 1)
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            mrst,
    input  logic            bump,
    input  logic            lmts,
    input  logic            wr_rc,
    input  logic [RC_W-1:0] wdata,
    output logic [RC_W-1:0] rc_q,
    output logic            ovf_evt
);
    localparam logic [RC_W-1:0] LIM_LO_V = RC_W'(LIMIT_LO);
    localparam logic [RC_W-1:0] LIM_HI_V = RC_W'(LIMIT_HI);

    logic [RC_W-1:0] limit;

    assign limit   = lmts ? LIM_LO_V : LIM_HI_V;
    assign ovf_evt = bump && (rc_q == limit);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       rc_q <= '0;
        else if (mrst)    rc_q <= '0;
        else if (wr_rc)   rc_q <= wdata;
        else if (ovf_evt) rc_q <= '0;
        else if (bump)    rc_q <= rc_q + 1'b1;
    end
endmodule

// File: rtl/rit_flag.sv
module rit_flag
    import rit_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic mrst,
    input  logic set_evt,
    input  logic sw_clr,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= FLAG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (mrst) begin
            state_d = FLAG_LOW;
        end else begin
            unique case (state_q)
                FLAG_LOW:  if (set_evt) state_d = FLAG_HIGH;
                FLAG_HIGH: if (sw_clr && !set_evt) state_d = FLAG_LOW;
                default:   state_d = FLAG_LOW;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            FLAG_HIGH: flag = 1'b1;
            default:   flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
    import rit_pkg::*;
#(
    parameter int TMR_W    = 8,
    parameter int SEL_W    = 3,
    parameter int LIMIT_LO = 512,
    parameter int LIMIT_HI = 1024,
    parameter int REG_W    = 11
) (
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    mrst,
    input  logic                    standby,
    input  logic [SEL_W-1:0]        tick_sel,
    input  logic [(1<<SEL_W)-2:0]   tick_vec,
    input  logic                    reg_we,
    input  logic [1:0]              reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    refresh_req,
    output logic                    irq
);
    localparam int RC_W = $clog2(LIMIT_HI + 1);

    logic            tick, match, ovf_evt;
    logic            wr_csr, wr_cnt, wr_cmp, wr_rc;
    logic [TMR_W-1:0] cnt_q, cmp_q;
    logic [RC_W-1:0] rc_q;
    logic            ovie_q, lmts_q, cmf_q, ovf_q;

    assign wr_csr = reg_we && (reg_addr == RA_CSR);
    assign wr_cnt = reg_we && (reg_addr == RA_CNT);
    assign wr_cmp = reg_we && (reg_addr == RA_CMP);
    assign wr_rc  = reg_we && (reg_addr == RA_RC);

    rit_tick_sel #(.SEL_W(SEL_W)) u_sel (
        .tick_sel(tick_sel), .tick_vec(tick_vec), .standby(standby), .tick(tick)
    );

    rit_interval #(.TMR_W(TMR_W)) u_int (
        .clk(clk), .por_n(por_n), .mrst(mrst), .tick(tick),
        .wr_cnt(wr_cnt), .wr_cmp(wr_cmp), .wdata(reg_wdata[TMR_W-1:0]),
        .cnt_q(cnt_q), .cmp_q(cmp_q), .match(match), .req_q(refresh_req)
    );

    rit_tally #(.LIMIT_LO(LIMIT_LO), .LIMIT_HI(LIMIT_HI)) u_tally (
        .clk(clk), .por_n(por_n), .mrst(mrst), .bump(match), .lmts(lmts_q),
        .wr_rc(wr_rc), .wdata(reg_wdata[RC_W-1:0]), .rc_q(rc_q), .ovf_evt(ovf_evt)
    );

    rit_flag u_cmf (
        .clk(clk), .por_n(por_n), .mrst(mrst), .set_evt(match),
        .sw_clr(wr_csr && !reg_wdata[CSR_CMF]), .flag(cmf_q)
    );

    rit_flag u_ovf (
        .clk(clk), .por_n(por_n), .mrst(mrst), .set_evt(ovf_evt),
        .sw_clr(wr_csr && !reg_wdata[CSR_OVF]), .flag(ovf_q)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ovie_q <= 1'b0;
            lmts_q <= 1'b0;
        end else if (mrst) begin
            ovie_q <= 1'b0;
            lmts_q <= 1'b0;
        end else if (wr_csr) begin
            ovie_q <= reg_wdata[CSR_OVIE];
            lmts_q <= reg_wdata[CSR_LMTS];
        end
    end

    assign irq = ovf_q && ovie_q;

    always_comb begin
        unique case (reg_addr)
            RA_CSR:  reg_rdata = REG_W'({cmf_q, ovf_q, ovie_q, lmts_q});
            RA_CNT:  reg_rdata = REG_W'(cnt_q);
            RA_CMP:  reg_rdata = REG_W'(cmp_q);
            default: reg_rdata = REG_W'(rc_q);
        endcase
    end
endmodule

// File: rtl/rit_checker.sv
module rit_checker #(
    parameter int TMR_W = 8,
    parameter int RC_W  = 11
) (
    input logic             clk,
    input logic             por_n,
    input logic             mrst,
    input logic             standby,
    input logic             wr_csr,
    input logic             wr_cnt,
    input logic             wr_rc,
    input logic             wd_ovf,
    input logic             refresh_req,
    input logic             irq,
    input logic [TMR_W-1:0] cnt_q,
    input logic [RC_W-1:0]  rc_q,
    input logic             cmf_q,
    input logic             ovf_q
);
    // R2
    req_sets_cmf_chk: assert property (@(posedge clk) disable iff (!por_n)
        refresh_req |-> cmf_q);

    // R5
    ovf_write_one_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ovf_q && wr_csr && wd_ovf && !mrst) |=> ovf_q);

    // R7
    irq_needs_ovf_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ovf_q |-> !irq);

    // R1
    standby_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (standby && !wr_cnt) |=> $stable(cnt_q));

    // R3
    tally_step_chk: assert property (@(posedge clk) disable iff (!por_n)
        (refresh_req && $past(!wr_rc) && $past(!mrst)) |->
            ((rc_q == $past(rc_q) + 1'b1) || (rc_q == '0 && ovf_q)));
endmodule

bind refresh_interval_timer rit_checker #(.TMR_W(TMR_W), .RC_W(RC_W)) u_chk (
    .clk(clk), .por_n(por_n), .mrst(mrst), .standby(standby),
    .wr_csr(wr_csr), .wr_cnt(wr_cnt), .wr_rc(wr_rc),
    .wd_ovf(reg_wdata[rit_pkg::CSR_OVF]), .refresh_req(refresh_req), .irq(irq),
    .cnt_q(cnt_q), .rc_q(rc_q), .cmf_q(cmf_q), .ovf_q(ovf_q)
);

// File: tb/test_refresh_interval_timer.sv
module test_refresh_interval_timer;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mrst = 1'b0;
    logic        standby = 1'b0;
    logic [2:0]  tick_sel = 3'd0;
    logic [6:0]  tick_vec = 7'h7F;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [10:0] reg_wdata = '0;
    logic [10:0] reg_rdata;
    logic        refresh_req, irq;

    int n_chk = 0;
    int n_bad = 0;
    int n_req = 0;
    logic [10:0] v;

    always #2.5 clk = ~clk;

    refresh_interval_timer i_refresh_interval_timer (
        .clk(clk), .por_n(por_n), .mrst(mrst), .standby(standby),
        .tick_sel(tick_sel), .tick_vec(tick_vec), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .refresh_req(refresh_req), .irq(irq)
    );

    always @(negedge clk) if (refresh_req) n_req++;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = 11'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [10:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        tick_sel = 3'd1;
        repeat (n) @(negedge clk);
        tick_sel = 3'd0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        // R8 power-on state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R8 reset register", int'(v), 0);
        end
        check("R8 reset req", int'(refresh_req), 0);
        check("R8 reset irq", int'(irq), 0);

        // R1 select sweep
        wr(2'd2, 255);
        for (int s = 0; s < 8; s++) begin
            for (int b = 0; b < 7; b++) begin
                wr(2'd1, 0);
                @(negedge clk);
                tick_vec = 7'(1 << b); tick_sel = 3'(s);
                repeat (4) @(negedge clk);
                tick_sel = 3'd0;
                rd(2'd1, v);
                check("R1 select", int'(v), (s != 0 && b == s - 1) ? 4 : 0);
            end
        end
        tick_vec = 7'h7F;
        wr(2'd1, 9);
        standby = 1'b1;
        run(6);
        standby = 1'b0;
        rd(2'd1, v);
        check("R1 standby hold", int'(v), 9);

        // R2 R3 interval sweep
        for (int c = 0; c < 24; c++) begin
            int cc, k;
            cc = (c < 20) ? c : 232 + c;
            k = 3 * (cc + 1) + cc / 2;
            wr(2'd1, 0); wr(2'd2, cc); wr(2'd3, 0); wr(2'd0, 0);
            n_req = 0;
            run(k);
            repeat (2) @(negedge clk);
            rd(2'd1, v);
            check("R2 counter residue", int'(v), k % (cc + 1));
            check("R2 request pulses", n_req, k / (cc + 1));
            rd(2'd3, v);
            check("R3 tally", int'(v), k / (cc + 1));
            rd(2'd0, v);
            check("R2 compare flag", int'(v[3]), 1);
        end

        // R9 counter write beats tick
        wr(2'd2, 200); wr(2'd1, 0);
        @(negedge clk); tick_sel = 3'd1;
        repeat (3) @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 11'd40;
        @(negedge clk);
        reg_we = 1'b0; tick_sel = 3'd0;
        rd(2'd1, v);
        check("R9 write over tick", int'(v), 40);

        // R4 full tally, both limits
        for (int l = 0; l < 2; l++) begin
            int lim;
            lim = l ? 512 : 1024;
            wr(2'd1, 0); wr(2'd2, 0); wr(2'd3, 0); wr(2'd0, l);
            run(lim);
            rd(2'd3, v);
            check("R4 tally at limit", int'(v), lim);
            rd(2'd0, v);
            check("R4 no early ovf", int'(v[2]), 0);
            run(1);
            rd(2'd3, v);
            check("R4 tally wraps", int'(v), 0);
            rd(2'd0, v);
            check("R4 ovf set", int'(v[2]), 1);
            check("R7 irq masked", int'(irq), 0);
            wr(2'd0, 4'b1110 | l);
            rd(2'd0, v);
            check("R7 irq enabled", int'(irq), 1);
            check("R5 write one keeps ovf", int'(v[2]), 1);
            wr(2'd0, 4'b0010 | l);
            rd(2'd0, v);
            check("R5 write zero clears ovf", int'(v[2]), 0);
            check("R5 write zero clears cmf", int'(v[3]), 0);
            check("R7 irq drops", int'(irq), 0);
        end

        // R6 set beats clear
        wr(2'd1, 0); wr(2'd2, 0); wr(2'd3, 512); wr(2'd0, 3);
        @(negedge clk);
        tick_sel = 3'd1;
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 11'd3;
        @(negedge clk);
        tick_sel = 3'd0; reg_we = 1'b0;
        rd(2'd0, v);
        check("R6 ovf set wins", int'(v[2]), 1);
        check("R6 cmf set wins", int'(v[3]), 1);
        check("R6 irq", int'(irq), 1);
        wr(2'd0, 3);
        rd(2'd0, v);
        check("R6 later clear", int'(v[3:2]), 0);

        // R8 manual reset
        wr(2'd2, 200); wr(2'd1, 77); wr(2'd3, 33); wr(2'd0, 15);
        @(negedge clk); mrst = 1'b1;
        repeat (3) @(negedge clk);
        tick_sel = 3'd1;
        repeat (5) @(negedge clk);
        tick_sel = 3'd0; mrst = 1'b0;
        rd(2'd1, v);
        check("R8 counter survives and counts", int'(v), 82);
        rd(2'd2, v);
        check("R8 constant kept", int'(v), 200);
        rd(2'd0, v);
        check("R8 csr cleared", int'(v), 0);
        rd(2'd3, v);
        check("R8 tally cleared", int'(v), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule